// File: doc/BRIEF.md
# Single-Wire Transfer Controller Register Block

This block is the host-facing register file of a controller for platform-environment-control transfers on a single-wire bus. The host sets up a transfer through a 32-bit register read/write port. It writes the target address, the byte counts and the outgoing bytes, and then launches the transfer by writing the command register. The wire-level bit engine sits behind an abstract port. It receives a one-cycle start pulse together with the setup values. It reports its state while it works. At the end it returns a done pulse with the received bytes, the captured check bytes, the timing-negotiation result and a set of error flags.

Every accepted transfer ends with command-done in the interrupt status register, whether it succeeded or failed. Any error flags are set in the same cycle. Status bits are cleared by writing ones to them. The interrupt output stays high as long as an enabled status bit is pending. The transmit and receive buffers each hold up to 32 bytes. Each buffer is reached through two separate windows of four words.

Top module: `wire_xfer_regs`

## Requirements
- R1: After reset, the control register reads 0x00080000 (sampling point 8), the interrupt status and command registers read 0, and `irq` and `engStart` are low.
- R2: Only the defined fields are writable, and all other bits read 0. The writable masks are: control 0x000F0731 at 0x00, timing 0x0000FFFF at 0x04, length 0x80FFFFFF at 0x0C (target 7:0, write length 15:8, read length 23:16, auto check byte 31), expected check 0x00FFFFFF at 0x10, interrupt enable 0xC000001F at 0x18.
- R3: Transmit byte n is stored in bits 8*(n%4)+7:8*(n%4) of one word. Bytes 0–15 sit in words 0x20–0x2C and bytes 16–31 in words 0x40–0x4C. Each word reads back as written and drives `engTxBytes[8n+7:8n]`.
- R4: A write with bit 0 set to the command register at 0x08 launches a transfer. The controller must be enabled (control bits 0 and 4 both 1), idle, and both lengths must be at most 32. The transfer starts with a single-cycle `engStart` in the cycle after the write. The engine outputs then carry the target, the lengths and the auto-check flag from 0x0C.
- R5: The command register reads bit 0 = transfer in flight, bits 27:24 = `engState` and bit 31 = `engPinMon`. A launch request while any of these is non-zero is ignored.
- R6: A launch request is ignored, and raises no status bit, when the controller is disabled or when either length is above 32.
- R7: `engDone` during an in-flight transfer always sets status bit 0 (done). It also sets bits 4:1 from `engErr[3:0]` (1 check-byte abort, 2 bad write check byte, 3 contention, 4 timeout) and ends the transfer. `engDone` with no transfer in flight changes nothing.
- R8: The receive bytes use the same byte placement as R3, with bytes 0–15 at 0x30–0x3C and 16–31 at 0x50–0x5C. They are captured from `engRxBytes` on an accepted done and stay unchanged until the next one.
- R9: On an accepted done, 0x14 captures the read check byte in bits 23:16 and the write check byte in bits 7:0. Status bits 29:16 capture the negotiation result.
- R10: Writing to the status register at 0x1C clears each of bits 4:0 written as 1 and leaves the others. A bit being set in the same cycle wins over the clear.
- R11: `irq` is high exactly while some status bit 4:0 is set and its enable bit at 0x18 is also set. It stays high until software clears those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Interrupt request |
| engStart | output | 1 | One-cycle transfer launch to the engine |
| engTarget | output | 8 | Target address |
| engWrLen | output | 8 | Bytes to transmit |
| engRdLen | output | 8 | Bytes to receive |
| engAutoChk | output | 1 | Automatic check byte enable |
| engTxBytes | output | 256 | Transmit buffer, byte n at bits 8n+7:8n |
| engState | input | 4 | Engine state, 0 when idle |
| engPinMon | input | 1 | Pin monitoring active |
| engDone | input | 1 | End of transfer pulse |
| engErr | input | 4 | Error flags valid with done |
| engRxBytes | input | 256 | Received bytes, valid with done |
| engCapWrChk | input | 8 | Captured write check byte |
| engCapRdChk | input | 8 | Captured read check byte |
| engNegoResult | input | 14 | Timing-negotiation result |

## Verification
Register reads are combinational, so a value written at one edge is due at the next sample point, half a cycle later. `engStart` is registered, so it is due in the half cycle right after the launching write and must be low again one cycle later. Status, captured data, receive words and `irq` change on the edge that samples `engDone`. The bench drives every input at a falling edge and samples half a cycle after the edge under test, so each check falls exactly in the cycle its result is due. Seeded random transfers with random lengths, errors and enables run alongside directed busy, disabled, oversize, stray-done and clear-collision cases.

// File: rtl/wxr_pkg.sv
package wxr_pkg;
  localparam logic [7:0] ADR_CTRL   = 8'h00;
  localparam logic [7:0] ADR_TIMING = 8'h04;
  localparam logic [7:0] ADR_CMD    = 8'h08;
  localparam logic [7:0] ADR_LEN    = 8'h0C;
  localparam logic [7:0] ADR_EXPCHK = 8'h10;
  localparam logic [7:0] ADR_CAPCHK = 8'h14;
  localparam logic [7:0] ADR_INTEN  = 8'h18;
  localparam logic [7:0] ADR_INTSTS = 8'h1C;
  localparam logic [7:0] ADR_TX_LO  = 8'h20;
  localparam logic [7:0] ADR_RX_LO  = 8'h30;
  localparam logic [7:0] ADR_TX_HI  = 8'h40;
  localparam logic [7:0] ADR_RX_HI  = 8'h50;

  localparam logic [31:0] MASK_CTRL   = 32'h000F_0731;
  localparam logic [31:0] MASK_TIMING = 32'h0000_FFFF;
  localparam logic [31:0] MASK_LEN    = 32'h80FF_FFFF;
  localparam logic [31:0] MASK_EXPCHK = 32'h00FF_FFFF;
  localparam logic [31:0] MASK_INTEN  = 32'hC000_001F;
  localparam logic [31:0] RST_CTRL    = 32'h0008_0000;

  localparam int NUM_IRQ = 5;

  typedef struct packed {
    logic capture;
  } ctlStrobe_t;
endpackage

// File: rtl/wxr_ctrl.sv
module wxr_ctrl
  import wxr_pkg::*;
#(
  parameter int MAX_BYTES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fireReq,
  input  logic [NUM_IRQ-1:0] statusClr,
  input  logic               xferEnabled,
  input  logic [7:0]         wrLen,
  input  logic [7:0]         rdLen,
  input  logic [NUM_IRQ-1:0] intEn,
  input  logic [3:0]         engState,
  input  logic               engPinMon,
  input  logic               engDone,
  input  logic [3:0]         engErr,
  output logic               engStart,
  output logic               inFlight,
  output logic [NUM_IRQ-1:0] intStatus,
  output ctlStrobe_t         strobe,
  output logic               irq
);
  localparam logic [7:0] LEN_MAX = 8'(MAX_BYTES);

  logic idle, lenOk, accept, doneAcc;

  assign idle    = !inFlight && (engState == 4'd0) && !engPinMon;
  assign lenOk   = (wrLen <= LEN_MAX) && (rdLen <= LEN_MAX);
  assign accept  = fireReq && idle && xferEnabled && lenOk;
  assign doneAcc = engDone && inFlight;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engStart  <= 1'b0;
      inFlight  <= 1'b0;
      intStatus <= '0;
    end else begin
      engStart <= accept;
      if (accept) inFlight <= 1'b1;
      else if (doneAcc) inFlight <= 1'b0;
      intStatus <= (intStatus & ~statusClr) |
                   (doneAcc ? {engErr, 1'b1} : '0);
    end
  end

  assign strobe.capture = doneAcc;
  assign irq = |(intStatus & intEn);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart); // R4
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !$past(inFlight)); // R5
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (wrLen <= LEN_MAX && rdLen <= LEN_MAX)); // R6
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && inFlight) |=> (intStatus[0] && !inFlight)); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && statusClr == '0 && $stable(intEn)) |=> irq); // R11
endmodule

// File: rtl/wxr_datapath.sv
module wxr_datapath
  import wxr_pkg::*;
#(
  parameter int MAX_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             regAddr,
  input  logic                   regWrEn,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  ctlStrobe_t             strobe,
  input  logic [NUM_IRQ-1:0]     intStatus,
  input  logic                   inFlight,
  input  logic [3:0]             engState,
  input  logic                   engPinMon,
  input  logic [8*MAX_BYTES-1:0] engRxBytes,
  input  logic [7:0]             engCapWrChk,
  input  logic [7:0]             engCapRdChk,
  input  logic [13:0]            engNegoResult,
  output logic                   fireReq,
  output logic [NUM_IRQ-1:0]     statusClr,
  output logic                   xferEnabled,
  output logic [7:0]             outTarget,
  output logic [7:0]             outWrLen,
  output logic [7:0]             outRdLen,
  output logic                   outAutoChk,
  output logic [NUM_IRQ-1:0]     intEn,
  output logic [8*MAX_BYTES-1:0] txFlat
);
  localparam int WORDS = MAX_BYTES / 4;
  localparam int HALF  = WORDS / 2;

  function automatic logic [7:0] winAddr(input logic [7:0] lo, input logic [7:0] hi, input int w);
    return (w < HALF) ? lo + 8'(4 * w) : hi + 8'(4 * (w - HALF));
  endfunction

  logic [31:0] ctrlReg, timingReg, lenReg, expReg, intEnReg, capReg;
  logic [13:0] negoReg;
  logic [31:0] txMem [WORDS];
  logic [31:0] rxMem [WORDS];

  function automatic logic hit(input logic [7:0] a);
    return regWrEn && (regAddr == a);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= RST_CTRL;
      timingReg <= '0;
      lenReg    <= '0;
      expReg    <= '0;
      intEnReg  <= '0;
      capReg    <= '0;
      negoReg   <= '0;
    end else begin
      if (hit(ADR_CTRL))   ctrlReg   <= regWrData & MASK_CTRL;
      if (hit(ADR_TIMING)) timingReg <= regWrData & MASK_TIMING;
      if (hit(ADR_LEN))    lenReg    <= regWrData & MASK_LEN;
      if (hit(ADR_EXPCHK)) expReg    <= regWrData & MASK_EXPCHK;
      if (hit(ADR_INTEN))  intEnReg  <= regWrData & MASK_INTEN;
      if (strobe.capture) begin
        capReg  <= {8'h00, engCapRdChk, 8'h00, engCapWrChk};
        negoReg <= engNegoResult;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txMem[w] <= '0;
        rxMem[w] <= '0;
      end else begin
        if (hit(winAddr(ADR_TX_LO, ADR_TX_HI, w))) txMem[w] <= regWrData;
        if (strobe.capture) rxMem[w] <= engRxBytes[32*w +: 32];
      end
    end
    assign txFlat[32*w +: 32] = txMem[w];
  end

  assign fireReq     = hit(ADR_CMD) && regWrData[0];
  assign statusClr   = hit(ADR_INTSTS) ? regWrData[NUM_IRQ-1:0] : '0;
  assign xferEnabled = ctrlReg[0] && ctrlReg[4];
  assign outTarget   = lenReg[7:0];
  assign outWrLen    = lenReg[15:8];
  assign outRdLen    = lenReg[23:16];
  assign outAutoChk  = lenReg[31];
  assign intEn       = intEnReg[NUM_IRQ-1:0];

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADR_CTRL:   regRdData = ctrlReg;
      ADR_TIMING: regRdData = timingReg;
      ADR_CMD:    regRdData = {engPinMon, 3'b000, engState, 23'd0, inFlight};
      ADR_LEN:    regRdData = lenReg;
      ADR_EXPCHK: regRdData = expReg;
      ADR_CAPCHK: regRdData = capReg;
      ADR_INTEN:  regRdData = intEnReg;
      ADR_INTSTS: regRdData = {2'b00, negoReg, 11'd0, intStatus};
      default: begin
        for (int w = 0; w < WORDS; w++) begin
          if (regAddr == winAddr(ADR_TX_LO, ADR_TX_HI, w)) regRdData = txMem[w];
          if (regAddr == winAddr(ADR_RX_LO, ADR_RX_HI, w)) regRdData = rxMem[w];
        end
      end
    endcase
  end

  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rxMem[0]) && $stable(rxMem[WORDS-1])); // R8
  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg & ~MASK_CTRL) == 32'd0); // R2
endmodule

// File: rtl/wire_xfer_regs.sv
module wire_xfer_regs
  import wxr_pkg::*;
#(
  parameter int MAX_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             regAddr,
  input  logic                   regWrEn,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  output logic                   irq,
  output logic                   engStart,
  output logic [7:0]             engTarget,
  output logic [7:0]             engWrLen,
  output logic [7:0]             engRdLen,
  output logic                   engAutoChk,
  output logic [8*MAX_BYTES-1:0] engTxBytes,
  input  logic [3:0]             engState,
  input  logic                   engPinMon,
  input  logic                   engDone,
  input  logic [3:0]             engErr,
  input  logic [8*MAX_BYTES-1:0] engRxBytes,
  input  logic [7:0]             engCapWrChk,
  input  logic [7:0]             engCapRdChk,
  input  logic [13:0]            engNegoResult
);
  ctlStrobe_t         strobe;
  logic [NUM_IRQ-1:0] intStatus, statusClr, intEn;
  logic               inFlight, fireReq, xferEnabled;

  wxr_datapath #(.MAX_BYTES(MAX_BYTES)) data_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .intStatus(intStatus), .inFlight(inFlight), .engState(engState),
    .engPinMon(engPinMon), .engRxBytes(engRxBytes), .engCapWrChk(engCapWrChk),
    .engCapRdChk(engCapRdChk), .engNegoResult(engNegoResult),
    .fireReq(fireReq), .statusClr(statusClr), .xferEnabled(xferEnabled),
    .outTarget(engTarget), .outWrLen(engWrLen), .outRdLen(engRdLen),
    .outAutoChk(engAutoChk), .intEn(intEn), .txFlat(engTxBytes)
  );

  wxr_ctrl #(.MAX_BYTES(MAX_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .fireReq(fireReq), .statusClr(statusClr),
    .xferEnabled(xferEnabled), .wrLen(engWrLen), .rdLen(engRdLen),
    .intEn(intEn), .engState(engState), .engPinMon(engPinMon),
    .engDone(engDone), .engErr(engErr), .engStart(engStart),
    .inFlight(inFlight), .intStatus(intStatus), .strobe(strobe), .irq(irq)
  );
endmodule

// File: tb/wire_xfer_regs_tb_top.sv
module wire_xfer_regs_tb_top;
  localparam int NB = 32;
  localparam int NW = NB / 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  logic irq, engStart, engAutoChk;
  logic [7:0] engTarget, engWrLen, engRdLen;
  logic [8*NB-1:0] engTxBytes;
  logic [3:0] engState = '0, engErr = '0;
  logic engPinMon = 1'b0, engDone = 1'b0;
  logic [8*NB-1:0] engRxBytes = '0;
  logic [7:0] engCapWrChk = '0, engCapRdChk = '0;
  logic [13:0] engNegoResult = '0;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] txB [NB];
  logic [7:0] rxB [NB];
  logic [4:0] curEn = '0;
  logic [3:0] curErr = '0;
  logic [13:0] curNego = '0;
  logic [7:0] curWc = '0, curRc = '0;

  always #5 clk = ~clk;

  wire_xfer_regs #(.MAX_BYTES(NB)) dut_i (.*);

  function automatic logic [7:0] wAddr(input bit isRx, input int w);
    logic [7:0] lo = isRx ? 8'h30 : 8'h20;
    logic [7:0] hi = isRx ? 8'h50 : 8'h40;
    return (w < NW / 2) ? lo + 8'(4 * w) : hi + 8'(4 * (w - NW / 2));
  endfunction

  function automatic logic [31:0] packTx(input int w);
    return {txB[4*w+3], txB[4*w+2], txB[4*w+1], txB[4*w]};
  endfunction

  function automatic logic [31:0] packRx(input int w);
    return {rxB[4*w+3], rxB[4*w+2], rxB[4*w+1], rxB[4*w]};
  endfunction

  function automatic logic [31:0] expStatus(input logic [4:0] bits);
    return {2'b00, curNego, 11'd0, bits};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Program setup and fire; when expectStart, complete via stub engine.
  task automatic xfer(input logic [7:0] wl, input logic [7:0] rl, input bit expectStart, input string req);
    logic [31:0] v;
    logic [4:0] expBits;
    logic [8*NB-1:0] txExp;
    wr(8'h0C, {1'b1, 7'd0, rl, wl, 8'h30});
    for (int w = 0; w < NW; w++) wr(wAddr(0, w), packTx(w));
    wr(8'h08, 32'h1);
    chk(engStart == expectStart, req, engStart, expectStart);
    if (expectStart) begin
      for (int n = 0; n < NB; n++) txExp[8*n +: 8] = txB[n];
      chk(engTxBytes == txExp && engWrLen == wl && engRdLen == rl && engTarget == 8'h30 && engAutoChk,
          "R3", engTxBytes[63:0], txExp[63:0]);
    end
    @(negedge clk);
    chk(engStart == 1'b0, "R4 pulse", engStart, 0);
    if (!expectStart) begin
      rd(8'h1C, v);
      chk(v[4:0] == 5'd0, "R6 no status", v, 0);
      return;
    end
    engState = 4'd2;
    rd(8'h08, v);
    chk(v == 32'h0200_0001, "R5 busy", v, 32'h0200_0001);
    wr(8'h08, 32'h1);
    chk(engStart == 1'b0, "R5 refire", engStart, 0);
    for (int n = 0; n < NB; n++) rxB[n] = 8'($urandom);
    for (int n = 0; n < NB; n++) engRxBytes[8*n +: 8] = rxB[n];
    curErr = 4'($urandom); curNego = 14'($urandom);
    curWc = 8'($urandom); curRc = 8'($urandom);
    engErr = curErr; engNegoResult = curNego; engCapWrChk = curWc; engCapRdChk = curRc;
    engDone = 1'b1; engState = 4'd0;
    @(negedge clk);
    engDone = 1'b0; engRxBytes = '0;
    expBits = {curErr, 1'b1};
    rd(8'h1C, v);
    chk(v == expStatus(expBits), "R7 R9 status", v, expStatus(expBits));
    rd(8'h08, v);
    chk(v == 32'h0, "R7 idle", v, 0);
    rd(8'h14, v);
    chk(v == {8'h0, curRc, 8'h0, curWc}, "R9 captured", v, {8'h0, curRc, 8'h0, curWc});
    for (int w = 0; w < NW; w++) begin
      rd(wAddr(1, w), v);
      chk(v == packRx(w), "R8 rx", v, packRx(w));
    end
    chk(irq == |(expBits & curEn), "R11 irq", irq, |(expBits & curEn));
    wr(8'h1C, 32'h1F);
    rd(8'h1C, v);
    chk(v[4:0] == 5'd0 && irq == 1'b0, "R10 clear", {irq, v}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int n = 0; n < NB; n++) begin txB[n] = 8'($urandom); rxB[n] = 8'h00; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd(8'h00, v); chk(v == 32'h0008_0000, "R1 ctrl", v, 32'h0008_0000);
    rd(8'h1C, v); chk(v == 0 && !irq && !engStart, "R1 status", {irq, engStart, v}, 0);
    rd(8'h08, v); chk(v == 0, "R1 cmd", v, 0);

    // R2 masks
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk(v == 32'h000F_0731, "R2 ctrl", v, 32'h000F_0731);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk(v == 32'h0000_FFFF, "R2 timing", v, 32'h0000_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk(v == 32'h80FF_FFFF, "R2 len", v, 32'h80FF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk(v == 32'h00FF_FFFF, "R2 expchk", v, 32'h00FF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk(v == 32'hC000_001F, "R2 inten", v, 32'hC000_001F);
    curEn = 5'h1F;

    // R3 tx window readback
    for (int w = 0; w < NW; w++) wr(wAddr(0, w), packTx(w));
    for (int w = 0; w < NW; w++) begin
      rd(wAddr(0, w), v); chk(v == packTx(w), "R3 tx", v, packTx(w));
    end

    // R6 disabled: control still has enables, so disable first
    wr(8'h00, 32'h0008_0001);
    xfer(8'd4, 8'd4, 0, "R6 disabled");
    wr(8'h00, 32'h0008_0011);

    // R7 stray done ignored
    engDone = 1'b1; engErr = 4'hF;
    @(negedge clk); engDone = 1'b0;
    rd(8'h1C, v); chk(v[4:0] == 0 && !irq, "R7 stray done", v, 0);

    // R5 busy by engine state / pin monitor
    engState = 4'd3;
    rd(8'h08, v); chk(v == 32'h0300_0000, "R5 state", v, 32'h0300_0000);
    wr(8'h08, 32'h1); chk(engStart == 0, "R5 state fire", engStart, 0);
    engState = 4'd0; engPinMon = 1'b1;
    rd(8'h08, v); chk(v == 32'h8000_0000, "R5 pinmon", v, 32'h8000_0000);
    wr(8'h08, 32'h1); chk(engStart == 0, "R5 pinmon fire", engStart, 0);
    engPinMon = 1'b0;

    // R6 oversize / R4 boundary
    xfer(8'd33, 8'd1, 0, "R6 wr oversize");
    xfer(8'd1, 8'd33, 0, "R6 rd oversize");
    xfer(8'd32, 8'd32, 1, "R4 max");
    xfer(8'd0, 8'd0, 1, "R4 zero");

    // R10 partial clear and set-wins collision; R11 hold
    wr(8'h18, 32'h0000_0003); curEn = 5'h03;
    wr(8'h0C, 32'h0000_0101); wr(8'h08, 32'h1);
    engErr = 4'b0001; engDone = 1'b1;
    @(negedge clk); engDone = 1'b0;
    rd(8'h1C, v); chk(v[4:0] == 5'b00011 && irq, "R11 set", {irq, v[4:0]}, 6'h23);
    wr(8'h1C, 32'h1); rd(8'h1C, v);
    chk(v[4:0] == 5'b00010 && irq, "R10 partial", {irq, v[4:0]}, 6'h22);
    wr(8'h1C, 32'h2); chk(!irq, "R11 drop", irq, 0);
    wr(8'h0C, 32'h0000_0101); wr(8'h08, 32'h1);
    @(negedge clk);
    regAddr = 8'h1C; regWrData = 32'h1F; regWrEn = 1'b1; engErr = 4'b0; engDone = 1'b1;
    @(negedge clk); regWrEn = 1'b0; engDone = 1'b0;
    rd(8'h1C, v); chk(v[4:0] == 5'b00001, "R10 set wins", v[4:0], 1);
    wr(8'h1C, 32'h1F);

    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [7:0] wl, rl;
      curEn = 5'($urandom);
      wr(8'h18, {2'($urandom), 25'd0, curEn});
      for (int n = 0; n < NB; n++) txB[n] = 8'($urandom);
      wl = 8'($urandom_range(0, 36)); rl = 8'($urandom_range(0, 36));
      xfer(wl, rl, (wl <= 32 && rl <= 32), "R4 random");
    end
    finish_run();
  end
endmodule